// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves data between two ports, A and B, and can do so in both directions at once. Each direction has its own storage register and three controls: a latch enable, a clock strobe and an output enable. With the latch enable high, the direction is transparent and the far port follows the near port. With the latch enable low, the direction holds its stored word, except that a rising strobe loads a fresh copy of the near port.

The output enable of the A-to-B direction is active high. The output enable of the B-to-A direction is active low. A disabled port is modelled as a cleared data output with a cleared per-bit enable vector, which stands for high impedance. The storage keeps operating while its port is disabled.

The data path is divided into slices of `SLICE_W` bits. With `GANGED = 0`, each slice has its own controls. With `GANGED = 1`, the controls of slice 0 govern every slice, so the block acts as one wide unit. The strobe and latch enable are sampled on one system clock. Each data input passes through a bus-hold stage: a port that nobody drives presents the last value that was driven onto it.

Top module: `xcvr_univ_reg`

## Requirements
- R1: While a slice's A-to-B latch enable is high, that slice of `b_data_o` equals the effective A input in the same cycle. The word present at each clock edge is also stored.
- R2: While a slice's A-to-B latch enable is low and its strobe shows no low-to-high change between two samples, that slice of `b_data_o` stays unchanged. This holds when the strobe is steady high, steady low, or falling.
- R3: A strobe sampled low at one clock edge and high at the next, with the latch enable low at that second edge, stores the effective A input present at that edge. This also applies in the cycle right after the latch enable falls.
- R4: The A-to-B output enable is active high. When a slice's enable is 0, that slice of `b_en_o` and of `b_data_o` is all zeros. When it is 1, `b_en_o` is all ones for that slice.
- R5: The B-to-A output enable `ba_oe_ni` is active low. When a slice's bit is 1, that slice of `a_en_o` and of `a_data_o` is all zeros. When it is 0, `a_en_o` is all ones for that slice.
- R6: The B-to-A direction offers the same transparent, hold and capture behaviour, using `ba_le_i`, `ba_strobe_i` and `b_data_i`.
- R7: Storage keeps loading while its outputs are disabled. Once enabled again, the port shows the word captured while it was disabled.
- R8: With `GANGED = 0`, a control bit with index s affects only bits [s*SLICE_W +: SLICE_W].
- R9: With `GANGED = 1`, the index-0 control bits govern all slices, and the other control bits are ignored.
- R10: When a port's drive flag is low, its effective input is the last value sampled on that port while the drive flag was high.
- R11: While `rst_ni` is low, both enable vectors and both data outputs are zero. After reset, both stores and both bus-hold values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_data_i | input | W | Value sensed on port A |
| a_drive_i | input | 1 | Port A is being driven by an external source |
| b_data_i | input | W | Value sensed on port B |
| b_drive_i | input | 1 | Port B is being driven by an external source |
| ab_le_i | input | NUM_SLICES | A-to-B latch enable per slice |
| ab_strobe_i | input | NUM_SLICES | A-to-B capture strobe per slice |
| ab_oe_i | input | NUM_SLICES | A-to-B output enable per slice, active high |
| ba_le_i | input | NUM_SLICES | B-to-A latch enable per slice |
| ba_strobe_i | input | NUM_SLICES | B-to-A capture strobe per slice |
| ba_oe_ni | input | NUM_SLICES | B-to-A output enable per slice, active low |
| b_data_o | output | W | Value driven onto port B |
| b_en_o | output | W | Per-bit drive enable of port B |
| a_data_o | output | W | Value driven onto port A |
| a_en_o | output | W | Per-bit drive enable of port A |

## Verification
Two functions can land on the same clock edge: the latch enable falling out of transparency, and a rising strobe capture. The bench lowers the latch enable and raises the strobe in the same cycle while presenting a new A word. It then judges the edge by requiring that B shows that new word, not the last transparent one. A second collision is a capture made while the output enable is low. That case is judged by the value B shows on the first cycle after the enable returns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic le;
    logic strobe;
    logic oe;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         drive_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (drive_i) hold_q <= data_i;
  end

  assign data_o = drive_i ? data_i : hold_q;

  assert_hold_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> hold_q == $past(data_i));
  assert_hold_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_i |=> $stable(hold_q));
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dir_ctrl_t    ctrl_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] en_o
);
  logic         strobe_q;
  logic [W-1:0] store_q;
  logic         rise;
  logic         oe_eff;
  logic [W-1:0] view;

  // strobe_q resets high: a strobe held high through reset is not an edge
  assign rise = ctrl_i.strobe & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      store_q  <= '0;
    end else begin
      strobe_q <= ctrl_i.strobe;
      if (ctrl_i.le || rise) store_q <= din_i;
    end
  end

  assign view   = ctrl_i.le ? din_i : store_q;
  assign oe_eff = ctrl_i.oe & rst_ni;
  assign dout_o = oe_eff ? view : '0;
  assign en_o   = {W{oe_eff}};

  assert_transparent_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.le |=> store_q == $past(din_i));
  assert_hold_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && !(ctrl_i.strobe && !strobe_q)) |=> $stable(store_q));
  assert_edge_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.le && ctrl_i.strobe && !strobe_q) |=> store_q == $past(din_i));
endmodule

// File: rtl/xcvr_univ_reg.sv
module xcvr_univ_reg
  import xcvr_pkg::*;
#(
  parameter int SLICE_W    = 18,
  parameter int NUM_SLICES = 2,
  parameter bit GANGED     = 1'b0,
  localparam int W         = SLICE_W * NUM_SLICES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          a_data_i,
  input  logic                  a_drive_i,
  input  logic [W-1:0]          b_data_i,
  input  logic                  b_drive_i,
  input  logic [NUM_SLICES-1:0] ab_le_i,
  input  logic [NUM_SLICES-1:0] ab_strobe_i,
  input  logic [NUM_SLICES-1:0] ab_oe_i,
  input  logic [NUM_SLICES-1:0] ba_le_i,
  input  logic [NUM_SLICES-1:0] ba_strobe_i,
  input  logic [NUM_SLICES-1:0] ba_oe_ni,
  output logic [W-1:0]          b_data_o,
  output logic [W-1:0]          b_en_o,
  output logic [W-1:0]          a_data_o,
  output logic [W-1:0]          a_en_o
);
  logic [W-1:0] a_eff, b_eff;

  xcvr_bus_hold #(.W(W)) a_hold_i (
    .clk_i, .rst_ni, .data_i(a_data_i), .drive_i(a_drive_i), .data_o(a_eff));
  xcvr_bus_hold #(.W(W)) b_hold_i (
    .clk_i, .rst_ni, .data_i(b_data_i), .drive_i(b_drive_i), .data_o(b_eff));

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    localparam int C  = GANGED ? 0 : s;
    localparam int LO = s * SLICE_W;
    dir_ctrl_t ab_ctrl, ba_ctrl;

    assign ab_ctrl = '{le: ab_le_i[C], strobe: ab_strobe_i[C], oe: ab_oe_i[C]};
    assign ba_ctrl = '{le: ba_le_i[C], strobe: ba_strobe_i[C], oe: ~ba_oe_ni[C]};

    xcvr_dir_path #(.W(SLICE_W)) ab_path_i (
      .clk_i, .rst_ni, .ctrl_i(ab_ctrl),
      .din_i (a_eff[LO +: SLICE_W]),
      .dout_o(b_data_o[LO +: SLICE_W]),
      .en_o  (b_en_o[LO +: SLICE_W]));

    xcvr_dir_path #(.W(SLICE_W)) ba_path_i (
      .clk_i, .rst_ni, .ctrl_i(ba_ctrl),
      .din_i (b_eff[LO +: SLICE_W]),
      .dout_o(a_data_o[LO +: SLICE_W]),
      .en_o  (a_en_o[LO +: SLICE_W]));

    assert_ab_oe_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ab_oe_i[C] |-> (b_en_o[LO +: SLICE_W] == '0 && b_data_o[LO +: SLICE_W] == '0));
    assert_ba_oe_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ba_oe_ni[C] |-> (a_en_o[LO +: SLICE_W] == '0 && a_data_o[LO +: SLICE_W] == '0));
  end
endmodule

// File: tb/xcvr_univ_reg_tb_top.sv
module xcvr_univ_reg_tb_top;
  localparam int SW = 18;
  localparam int NS = 2;
  localparam int W  = SW * NS;
  localparam logic [W-1:0] ALL = '1;
  localparam logic [W-1:0] LOM = 36'h00003FFFF;
  localparam logic [W-1:0] A1 = 36'h123456789, A2 = 36'h9ABCDEF01, A3 = 36'h0F0F0F0F0;
  localparam logic [W-1:0] A4 = 36'hCAFE01234, A5 = 36'h5A5A5A5A5, A6 = 36'h876543210;
  localparam logic [W-1:0] A7 = 36'h3C3C3C3C3, A8 = 36'h111222333, A9 = 36'hEEEDDDCCC;
  localparam logic [W-1:0] B1 = 36'h0000FFFF1, B2 = 36'hABCDEF123, BJ = 36'h999999999;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_drv = 1'b1, b_drv = 1'b1;
  logic [NS-1:0] ab_le = '0, ab_cp = '0, ab_oe = '0, ba_le = '0, ba_cp = '0, ba_oen = '1;
  logic [W-1:0] b_d, b_e, a_d, a_e, g_bd, g_be, g_ad, g_ae;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string        req;
    logic [W-1:0] bd, be, ad, ae, gb;
    bit           chk_g;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  xcvr_univ_reg #(.SLICE_W(SW), .NUM_SLICES(NS), .GANGED(1'b0)) dut_i (
    .clk_i(clk), .rst_ni, .a_data_i(a_in), .a_drive_i(a_drv), .b_data_i(b_in),
    .b_drive_i(b_drv), .ab_le_i(ab_le), .ab_strobe_i(ab_cp), .ab_oe_i(ab_oe),
    .ba_le_i(ba_le), .ba_strobe_i(ba_cp), .ba_oe_ni(ba_oen),
    .b_data_o(b_d), .b_en_o(b_e), .a_data_o(a_d), .a_en_o(a_e));

  xcvr_univ_reg #(.SLICE_W(SW), .NUM_SLICES(NS), .GANGED(1'b1)) gang_i (
    .clk_i(clk), .rst_ni, .a_data_i(a_in), .a_drive_i(a_drv), .b_data_i(b_in),
    .b_drive_i(b_drv), .ab_le_i(ab_le), .ab_strobe_i(ab_cp), .ab_oe_i(ab_oe),
    .ba_le_i(ba_le), .ba_strobe_i(ba_cp), .ba_oe_ni(ba_oen),
    .b_data_o(g_bd), .b_en_o(g_be), .a_data_o(g_ad), .a_en_o(g_ae));

  // driver: inputs already applied; push what must be visible after the next edge
  task automatic tick(input string req, input logic [W-1:0] bd, be, ad, ae,
                      input bit chk_g = 1'b0, input logic [W-1:0] gb = '0);
    exp_t it;
    @(posedge clk);
    it = '{req: req, bd: bd, be: be, ad: ad, ae: ae, gb: gb, chk_g: chk_g};
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_run++;
        if (b_d !== it.bd || b_e !== it.be || a_d !== it.ad || a_e !== it.ae) begin
          n_fail++;
          $display("FAIL %s: b_d=%h b_e=%h a_d=%h a_e=%h exp b_d=%h b_e=%h a_d=%h a_e=%h",
                   it.req, b_d, b_e, a_d, a_e, it.bd, it.be, it.ad, it.ae);
        end
        if (it.chk_g) begin
          n_run++;
          if (g_bd !== it.gb) begin
            n_fail++;
            $display("FAIL %s ganged: b_d=%h exp %h", it.req, g_bd, it.gb);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    ab_oe = 2'b11; ba_oen = 2'b00;
    tick("R11", '0, '0, '0, '0);                     // enables masked in reset
    rst_ni = 1'b1;
    tick("R11", '0, ALL, '0, ALL);                   // cleared stores
    ab_le = 2'b11; a_in = A1;
    tick("R1", A1, ALL, '0, ALL);
    ab_le = 2'b00; a_in = A2;
    tick("R2", A1, ALL, '0, ALL);
    ab_cp = 2'b11;
    tick("R3", A2, ALL, '0, ALL);
    a_in = A3;
    tick("R2", A2, ALL, '0, ALL);                    // steady high strobe
    ab_cp = 2'b00;
    tick("R2", A2, ALL, '0, ALL);                    // falling strobe
    ab_cp = 2'b11;
    tick("R3", A3, ALL, '0, ALL);
    ab_oe = 2'b00;
    tick("R4", '0, '0, '0, ALL);
    ab_cp = 2'b00; a_in = A4;
    tick("R7", '0, '0, '0, ALL);
    ab_cp = 2'b11;
    tick("R7", '0, '0, '0, ALL);                     // capture while disabled
    ab_oe = 2'b11;
    tick("R7", A4, ALL, '0, ALL);
    ab_le = 2'b11; a_in = A5;
    tick("R1", A5, ALL, '0, ALL);
    ab_cp = 2'b00;
    tick("R1", A5, ALL, '0, ALL);
    ab_le = 2'b00; ab_cp = 2'b11; a_in = A6;         // le falls with rising strobe
    tick("R3", A6, ALL, '0, ALL);
    ab_cp = 2'b00;
    tick("R2", A6, ALL, '0, ALL);
    a_in = A7; ab_cp = 2'b01;
    tick("R8", {A6[W-1:SW], A7[SW-1:0]}, ALL, '0, ALL, 1'b1, A7);
    ab_oe = 2'b01;
    tick("R9", {{SW{1'b0}}, A7[SW-1:0]}, LOM, '0, ALL, 1'b1, A7);
    ba_le = 2'b11; b_in = B1;
    tick("R6", {{SW{1'b0}}, A7[SW-1:0]}, LOM, B1, ALL);
    ba_le = 2'b00; b_in = B2;
    tick("R6", {{SW{1'b0}}, A7[SW-1:0]}, LOM, B1, ALL);
    ba_cp = 2'b11;
    tick("R6", {{SW{1'b0}}, A7[SW-1:0]}, LOM, B2, ALL);
    ba_oen = 2'b11;
    tick("R5", {{SW{1'b0}}, A7[SW-1:0]}, LOM, '0, '0);
    ba_oen = 2'b01;
    tick("R5", {{SW{1'b0}}, A7[SW-1:0]}, LOM, {B2[W-1:SW], {SW{1'b0}}}, ALL & ~LOM);
    ba_oen = 2'b00;
    tick("R5", {{SW{1'b0}}, A7[SW-1:0]}, LOM, B2, ALL);
    ab_oe = 2'b11; ab_le = 2'b11; a_in = A8;
    tick("R10", A8, ALL, B2, ALL);
    a_drv = 1'b0; a_in = A9;
    tick("R10", A8, ALL, B2, ALL);                   // undriven A holds A8
    a_drv = 1'b1;
    tick("R10", A9, ALL, B2, ALL);
    b_drv = 1'b0; b_in = BJ; ba_le = 2'b11;
    tick("R10", A9, ALL, B2, ALL);                   // undriven B holds B2
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule